// File: doc/BRIEF.md
# Two-Level Descriptor Cookie Translator

This block converts a 20-bit descriptor cookie into the 64-bit virtual address of a descriptor. It walks two tables to do this. The upper cookie field picks an entry in a primary table that sits in local memory, and that entry gives the physical base of a secondary page. The lower cookie field then picks an 8-byte slot in that page. The 64-bit word read from the slot is the result.

A configuration input sets the byte base of the primary table and its entry format. In the wide format each entry is a full 64-bit page address. In the packed format each entry is 32 bits, and the page address is that value shifted left by 12. The block handles one walk at a time. It returns the original cookie with the address, together with two error flags. One flag marks a cookie that is malformed or lies outside the table. The other marks a primary entry that points at no page.

Top module: `cookie_xlate`

## Requirements
- R1: The cookie field at bits 8:0 is the slot offset within a secondary page. The field at bits 19:9 is the primary index.
- R2: When `cfg_aligned` is 0, the primary read goes to byte address `cfg_base + index*8` (modulo 2^32). The 64-bit word returned is the page base.
- R3: When `cfg_aligned` is 1, the primary read goes to `cfg_base + index[10:1]*8`. Index bit 0 picks the half of the word: 1 takes bits 63:32 and 0 takes bits 31:0. The page base is that 32-bit value shifted left by 12.
- R4: The secondary read goes to page base + offset*8. The 64-bit word it returns is presented on `out_addr`.
- R5: If any cookie bit above bit 19 is set, the result carries `out_err_range`=1, `out_addr`=0, and no read is issued on either memory port.
- R6: The primary table fills a 4096-byte region. An index of 512 or more in wide mode, or 1024 or more in packed mode, gives the same result as R5: `out_err_range`=1, `out_addr`=0, and no read.
- R7: If the selected primary entry is zero, the result carries `out_err_page`=1 and `out_addr`=0, and no secondary read is issued.
- R8: Only one walk is active at a time. `in_ready` is high only while no walk is active. A result on `out_valid` holds its values until `out_ready` is seen.
- R9: `out_cookie` returns the full accepted cookie unchanged.
- R10: `cfg_base` and `cfg_aligned` are sampled when the cookie is accepted. Changing them during a walk has no effect on that walk.
- R11: After reset, `in_ready`=1, `out_valid`=0, and no memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Byte base of the primary table |
| cfg_aligned | input | 1 | 1 selects packed 32-bit entries, 0 selects wide 64-bit entries |
| in_valid | input | 1 | Cookie valid |
| in_ready | output | 1 | Cookie accepted at this edge when valid |
| in_cookie | input | 32 | Cookie to translate |
| pt_req_valid | output | 1 | One-cycle primary table read request |
| pt_req_addr | output | 32 | Byte address of the 64-bit primary word |
| pt_rsp_valid | input | 1 | Primary read data valid |
| pt_rsp_data | input | 64 | Primary read data |
| sp_req_valid | output | 1 | One-cycle secondary page read request |
| sp_req_addr | output | 64 | Byte address of the secondary slot |
| sp_rsp_valid | input | 1 | Secondary read data valid |
| sp_rsp_data | input | 64 | Secondary read data |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_cookie | output | 32 | Cookie of this result |
| out_addr | output | 64 | Translated descriptor address, 0 on error |
| out_err_range | output | 1 | Cookie malformed or outside the table |
| out_err_page | output | 1 | Primary entry was zero |

## Verification
The assertions check ordering rules on every cycle. A primary request only follows an acceptance. A secondary request only follows a primary response. An out-of-range cookie never reaches a memory port. A held result keeps its values, and `in_ready` is never high while a result waits. The packed-mode slot alignment is also checked whenever a secondary request is made.

Only the bench's scenarios can show that the addresses and the returned data are correct for each mode. The same goes for the choice of word half, the zero-entry handling, and the index limits at 511/512 and 1023/1024. They also show that configuration changes made during a walk are ignored. A reference model in the bench computes these results.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int OFF_W      = 9;
    localparam int IDX_W      = 11;
    localparam int FIELD_W    = OFF_W + IDX_W;
    localparam int SLOT_SH    = 3;
    localparam int PAGE_SH    = 12;
    localparam int WORD_W     = 64;
    localparam int HALF_W     = WORD_W / 2;
    localparam int BOFF_W     = IDX_W + SLOT_SH;
    localparam int WIDE_LIM_B = 9;   // wide entries: index below 2**9 fits 4 KB
    localparam int PACK_LIM_B = 10;  // packed entries: index below 2**10 fits 4 KB

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PT_WAIT = 2'd1,
        ST_SP_WAIT = 2'd2,
        ST_DONE    = 2'd3
    } walk_st_e;
endpackage

// File: rtl/xlate_decode.sv
module xlate_decode
    import xlate_pkg::*;
#(
    parameter int COOKIE_W  = 32,
    parameter int PT_ADDR_W = 32
) (
    input  logic [COOKIE_W-1:0]  cookie,
    input  logic                 aligned,
    input  logic [PT_ADDR_W-1:0] base,
    output logic [OFF_W-1:0]     off,
    output logic                 half_sel,
    output logic [PT_ADDR_W-1:0] pt_addr,
    output logic                 range_err
);
    logic [IDX_W-1:0]  idx;
    logic [BOFF_W-1:0] byte_off;
    logic              hi_bad;
    logic              idx_bad;

    assign off      = cookie[OFF_W-1:0];
    assign idx      = cookie[FIELD_W-1:OFF_W];
    assign half_sel = idx[0];

    generate
        if (COOKIE_W > FIELD_W) begin : g_hi
            assign hi_bad = |cookie[COOKIE_W-1:FIELD_W];
        end else begin : g_nohi
            assign hi_bad = 1'b0;
        end
    endgenerate

    always_comb begin
        if (aligned) begin
            byte_off = {1'b0, idx[IDX_W-1:1], {SLOT_SH{1'b0}}};
            idx_bad  = |idx[IDX_W-1:PACK_LIM_B];
        end else begin
            byte_off = {idx, {SLOT_SH{1'b0}}};
            idx_bad  = |idx[IDX_W-1:WIDE_LIM_B];
        end
    end

    assign pt_addr   = base + PT_ADDR_W'(byte_off);
    assign range_err = hi_bad | idx_bad;
endmodule

// File: rtl/xlate_entry_sel.sv
module xlate_entry_sel
    import xlate_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              aligned,
    input  logic              half_sel,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] page,
    output logic              page_zero,
    output logic [WORD_W-1:0] slot_addr
);
    logic [HALF_W-1:0] packed_ent;

    assign packed_ent = half_sel ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];

    always_comb begin
        if (aligned) begin
            page      = {{(WORD_W-HALF_W-PAGE_SH){1'b0}}, packed_ent, {PAGE_SH{1'b0}}};
            page_zero = (packed_ent == '0);
        end else begin
            page      = word;
            page_zero = (word == '0);
        end
    end

    assign slot_addr = page + WORD_W'({off, {SLOT_SH{1'b0}}});
endmodule

// File: rtl/cookie_xlate.sv
module cookie_xlate
    import xlate_pkg::*;
#(
    parameter int COOKIE_W  = 32,
    parameter int PT_ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PT_ADDR_W-1:0] cfg_base,
    input  logic                 cfg_aligned,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [COOKIE_W-1:0]  in_cookie,
    output logic                 pt_req_valid,
    output logic [PT_ADDR_W-1:0] pt_req_addr,
    input  logic                 pt_rsp_valid,
    input  logic [WORD_W-1:0]    pt_rsp_data,
    output logic                 sp_req_valid,
    output logic [WORD_W-1:0]    sp_req_addr,
    input  logic                 sp_rsp_valid,
    input  logic [WORD_W-1:0]    sp_rsp_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [COOKIE_W-1:0]  out_cookie,
    output logic [WORD_W-1:0]    out_addr,
    output logic                 out_err_range,
    output logic                 out_err_page
);
    typedef struct packed {
        walk_st_e               st;
        logic [COOKIE_W-1:0]    cookie;
        logic                   aligned;
        logic [OFF_W-1:0]       off;
        logic                   half;
        logic [PT_ADDR_W-1:0]   pt_addr;
        logic                   pt_req;
        logic [WORD_W-1:0]      sp_addr;
        logic                   sp_req;
        logic [WORD_W-1:0]      va;
        logic                   err_range;
        logic                   err_page;
    } walk_t;

    walk_t r_q, r_d;

    logic [OFF_W-1:0]     dec_off;
    logic                 dec_half;
    logic [PT_ADDR_W-1:0] dec_pt_addr;
    logic                 dec_err;
    logic [WORD_W-1:0]    sel_page;
    logic                 sel_zero;
    logic [WORD_W-1:0]    sel_slot;

    xlate_decode #(.COOKIE_W(COOKIE_W), .PT_ADDR_W(PT_ADDR_W)) i_decode (
        .cookie    (in_cookie),
        .aligned   (cfg_aligned),
        .base      (cfg_base),
        .off       (dec_off),
        .half_sel  (dec_half),
        .pt_addr   (dec_pt_addr),
        .range_err (dec_err)
    );

    xlate_entry_sel i_entry_sel (
        .word      (pt_rsp_data),
        .aligned   (r_q.aligned),
        .half_sel  (r_q.half),
        .off       (r_q.off),
        .page      (sel_page),
        .page_zero (sel_zero),
        .slot_addr (sel_slot)
    );

    always_comb begin
        r_d        = r_q;
        r_d.pt_req = 1'b0;
        r_d.sp_req = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.cookie    = in_cookie;
                    r_d.aligned   = cfg_aligned;
                    r_d.off       = dec_off;
                    r_d.half      = dec_half;
                    r_d.pt_addr   = dec_pt_addr;
                    r_d.err_range = dec_err;
                    r_d.err_page  = 1'b0;
                    r_d.va        = '0;
                    if (dec_err) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.pt_req = 1'b1;
                        r_d.st     = ST_PT_WAIT;
                    end
                end
            end
            ST_PT_WAIT: begin
                if (pt_rsp_valid) begin
                    if (sel_zero) begin
                        r_d.err_page = 1'b1;
                        r_d.st       = ST_DONE;
                    end else begin
                        r_d.sp_addr = sel_slot;
                        r_d.sp_req  = 1'b1;
                        r_d.st      = ST_SP_WAIT;
                    end
                end
            end
            ST_SP_WAIT: begin
                if (sp_rsp_valid) begin
                    r_d.va = sp_rsp_data;
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                if (out_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready      = (r_q.st == ST_IDLE);
    assign out_valid     = (r_q.st == ST_DONE);
    assign pt_req_valid  = r_q.pt_req;
    assign pt_req_addr   = r_q.pt_addr;
    assign sp_req_valid  = r_q.sp_req;
    assign sp_req_addr   = r_q.sp_addr;
    assign out_cookie    = r_q.cookie;
    assign out_addr      = r_q.va;
    assign out_err_range = r_q.err_range;
    assign out_err_page  = r_q.err_page;

    // page base of a packed entry has 12 clear bits; used by the slot check
    logic [PAGE_SH-1:0] page_low;
    assign page_low = sel_page[PAGE_SH-1:0];

    AST_PT_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |-> $past(in_valid && in_ready)); // R8
    AST_NO_ACCESS_ON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ((in_cookie >> FIELD_W) != '0))
        |=> (!pt_req_valid && out_valid && out_err_range)); // R5
    AST_SP_AFTER_PT: assert property (@(posedge clk) disable iff (!rst_n)
        sp_req_valid |-> $past(pt_rsp_valid)); // R4
    AST_PAGE_ERR_FROM_PT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && out_err_page) |-> ($past(pt_rsp_valid) && !sp_req_valid)); // R7
    AST_PACKED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_req_valid && r_q.aligned)
        |-> (sp_req_addr[PAGE_SH-1:0] == PAGE_SH'({r_q.off, {SLOT_SH{1'b0}}}))); // R3
    AST_PACKED_PAGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_rsp_valid && r_q.aligned) |-> (page_low == '0)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_addr) && $stable(out_cookie) && $stable(out_err_page))); // R8
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
endmodule

// File: tb/test_cookie_xlate.sv
module test_cookie_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic        cfg_aligned = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_cookie = '0;
    logic        pt_req_valid;
    logic [31:0] pt_req_addr;
    logic        pt_rsp_valid = 1'b0;
    logic [63:0] pt_rsp_data = '0;
    logic        sp_req_valid;
    logic [63:0] sp_req_addr;
    logic        sp_rsp_valid = 1'b0;
    logic [63:0] sp_rsp_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_cookie;
    logic [63:0] out_addr;
    logic        out_err_range;
    logic        out_err_page;

    int checks = 0;
    int errors = 0;
    int pt_cnt = 0;
    int sp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cookie_xlate i_cookie_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_aligned(cfg_aligned),
        .in_valid(in_valid), .in_ready(in_ready), .in_cookie(in_cookie),
        .pt_req_valid(pt_req_valid), .pt_req_addr(pt_req_addr),
        .pt_rsp_valid(pt_rsp_valid), .pt_rsp_data(pt_rsp_data),
        .sp_req_valid(sp_req_valid), .sp_req_addr(sp_req_addr),
        .sp_rsp_valid(sp_rsp_valid), .sp_rsp_data(sp_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_cookie(out_cookie),
        .out_addr(out_addr), .out_err_range(out_err_range), .out_err_page(out_err_page)
    );

    // primary memory contents: zero lower half at word slot 3, zero upper at 9, both at 15
    function automatic logic [63:0] pt_word(input logic [31:0] a);
        logic [31:0] lo, hi;
        lo = (a * 32'h9E37_79B9) ^ 32'h1357_9BDF;
        hi = a ^ 32'hC0DE_0000;
        if (a[6:3] == 4'd3 || a[6:3] == 4'd15) lo = '0;
        if (a[6:3] == 4'd9 || a[6:3] == 4'd15) hi = '0;
        return {hi, lo};
    endfunction

    function automatic logic [63:0] sp_word(input logic [63:0] a);
        return a ^ 64'hF0E1_D2C3_B4A5_9687;
    endfunction

    function automatic void model(input logic [31:0] ck, input logic al, input logic [31:0] base,
                                  output logic er, output logic ep, output logic [63:0] va);
        logic [10:0] idx;
        logic [8:0]  off;
        logic [31:0] pa;
        logic [63:0] w, page;
        logic [31:0] ent;
        idx = ck[19:9];
        off = ck[8:0];
        er = (ck[31:20] != 0) || (al ? (idx >= 11'd1024) : (idx >= 11'd512));
        ep = 1'b0;
        va = '0;
        if (er) return;
        pa = al ? base + {20'd0, idx[10:1], 3'b000} : base + {18'd0, idx, 3'b000};
        w = pt_word(pa);
        if (al) begin
            ent  = idx[0] ? w[63:32] : w[31:0];
            page = {20'd0, ent, 12'd0};
        end else begin
            page = w;
        end
        if (page == 0) begin
            ep = 1'b1;
            return;
        end
        va = sp_word(page + {52'd0, off, 3'b000});
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // memory responders
    initial begin
        forever begin
            @(negedge clk);
            if (pt_req_valid) begin
                logic [31:0] a;
                int lat;
                pt_cnt++;
                a = pt_req_addr;
                lat = $urandom % 3;
                repeat (lat) @(negedge clk);
                pt_rsp_data  = pt_word(a);
                pt_rsp_valid = 1'b1;
                @(negedge clk);
                pt_rsp_valid = 1'b0;
                pt_rsp_data  = $urandom;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (sp_req_valid) begin
                logic [63:0] a;
                int lat;
                sp_cnt++;
                a = sp_req_addr;
                lat = $urandom % 4;
                repeat (lat) @(negedge clk);
                sp_rsp_data  = sp_word(a);
                sp_rsp_valid = 1'b1;
                @(negedge clk);
                sp_rsp_valid = 1'b0;
            end
        end
    end

    task automatic walk(input logic [31:0] ck, input logic al, input logic [31:0] base,
                        input int hold, input string tag);
        logic er, ep;
        logic [63:0] va;
        int pt0, sp0;
        model(ck, al, base, er, ep, va);
        @(negedge clk);
        pt0 = pt_cnt;
        sp0 = sp_cnt;
        cfg_aligned = al;
        cfg_base    = base;
        in_cookie   = ck;
        in_valid    = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid    = 1'b0;
        cfg_aligned = ~al;                     // R10: changes after acceptance are ignored
        cfg_base    = $urandom;
        in_cookie   = $urandom;
        while (!out_valid) @(negedge clk);
        for (int i = 0; i < hold; i++) @(negedge clk);
        chk({tag, " R8 held valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " R8 ready low"}, {63'd0, in_ready}, 64'd0);
        chk({tag, " R9 cookie"}, {32'd0, out_cookie}, {32'd0, ck});
        chk({tag, " R5/R6 range flag"}, {63'd0, out_err_range}, {63'd0, er});
        chk({tag, " R7 page flag"}, {63'd0, out_err_page}, {63'd0, ep});
        chk({tag, " R4 address"}, out_addr, va);
        if (er) chk({tag, " R5 no primary read"}, 64'(pt_cnt - pt0), 64'd0);
        if (er || ep) chk({tag, " R7 no secondary read"}, 64'(sp_cnt - sp0), 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({tag, " R8 released"}, {62'd0, out_valid, in_ready}, 64'd1);
    endtask

    function automatic logic [31:0] mk(input int idx, input int off);
        return {12'd0, 11'(idx), 9'(off)};
    endfunction

    initial begin
        bit done;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R11 ready at reset", {63'd0, in_ready}, 64'd1);
        chk("R11 no result at reset", {63'd0, out_valid}, 64'd0);
        chk("R11 no request at reset", {62'd0, pt_req_valid, sp_req_valid}, 64'd0);
        rst_n = 1'b1;
        // directed corners
        walk(mk(0, 0),      1'b0, 32'h0000_1000, 0, "R1 R2 wide first");
        walk(mk(511, 511),  1'b0, 32'h0002_0000, 2, "R1 R2 wide last");
        walk(mk(512, 7),    1'b0, 32'h0002_0000, 0, "R6 wide beyond");
        walk(mk(1022, 5),   1'b1, 32'h0003_0008, 0, "R3 packed even");
        walk(mk(1023, 5),   1'b1, 32'h0003_0008, 3, "R3 packed odd");
        walk(mk(1024, 1),   1'b1, 32'h0003_0008, 0, "R6 packed beyond");
        walk(32'h0010_0000 | mk(4, 4), 1'b0, 32'h0, 0, "R5 high bit wide");
        walk(32'h8000_0000 | mk(4, 4), 1'b1, 32'h0, 1, "R5 high bit packed");
        walk(mk(6, 9),  1'b1, 32'h0, 0, "R7 packed zero low");   // word 3, half 0
        walk(mk(19, 9), 1'b1, 32'h0, 0, "R7 packed zero high");  // word 9, half 1
        walk(mk(15, 2), 1'b0, 32'h0, 0, "R7 wide zero");         // word 15
        walk(mk(7, 3),  1'b1, 32'h0, 4, "R3 R10 packed other half");
        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [31:0] ck;
            int idx;
            idx = $urandom % 1100;
            ck  = mk(idx, $urandom % 512);
            if ($urandom % 16 == 0) ck[31:20] = 12'($urandom);
            walk(ck, 1'($urandom), {$urandom, 3'b000} >> 3 << 3, $urandom % 3, "R1 R2 R3 R4 random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8 got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule